// File: doc/BRIEF.md
# Serial Transmit Engine with Flow Gating and Line Break

The block turns characters into asynchronous serial frames. Characters are pushed into an internal 32-entry first-in-first-out queue. A frame sequencer takes them out one at a time and sends each on `txd`. The frame starts with a low start bit. The data bits follow, least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts 16 pulses of the externally supplied oversample tick `os_tick`, so bit timing follows the tick and not the system clock. Frame settings are captured when a character is taken from the queue. Changing the settings mid-frame therefore never corrupts the frame on the wire.

The sequencer has five named states. `ST_IDLE` holds the line high. `ST_START` drives the start bit, `ST_DATA` shifts out the data bits and `ST_PARITY` sends the parity bit. `ST_STOP` sends one or two stop bits. Its transitions are:

- IDLE→START when the queue holds a character and flow gating allows it. The character is popped at this point.
- START→DATA at the end of the start bit.
- DATA→PARITY or DATA→STOP after the last data bit, depending on whether parity is enabled.
- PARITY→STOP at the end of the parity bit.
- STOP→START (back-to-back) at the end of the last stop bit, if another character may begin.
- STOP→IDLE otherwise.

Flow gating, when enabled, lets a character begin only while `cts` is high. A forced break overrides the line to low. The block reports:

- a queue-full flag;
- a busy flag that covers both the queue and the frame in flight;
- a level-based interrupt;
- a DMA request.

Top module: `serial_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `fifo_full` is 0, `tx_irq` is 1, and `tx_dma_req` equals `cfg_dma_en`.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. The number of data bits is `cfg_wlen` + 5: code 0 gives 5 bits and code 3 gives 8 bits. Data bits above that width are not sent.
- R3: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_even`=1 it makes the count of ones in data plus parity even; with 0 it makes that count odd. With `cfg_par_en`=0, no parity bit is sent.
- R4: `cfg_two_stop`=0 sends one high stop bit and 1 sends two. Back-to-back frames start exactly 16×(1 + data + parity + stop) tick periods apart.
- R5: Every bit lasts 16 `os_tick` pulses. The frame does not advance in cycles without a tick.
- R6: With `cfg_cts_en`=1, no character begins while `cts` is 0. With `cfg_cts_en`=0, `cts` has no effect.
- R7: If `cts` drops while a frame is on the line, that frame completes in full. The next character is held until `cts` returns.
- R8: While `cfg_break` is 1, `txd` is held at 0 on every cycle. Once it is cleared, the line returns to its normal value.
- R9: The queue holds 32 characters, and `fifo_full` is 1 when it is full. A push while full is dropped and is never transmitted.
- R10: `busy` is 1 while the queue is non-empty or a frame is on the line. It falls only after the last stop bit of the final character ends.
- R11: `tx_irq` is 1 when the queue fill level is at most `irq_level`. Values of `irq_level` below 4 act as 4.
- R12: `tx_dma_req` is 1 exactly when `cfg_dma_en` is 1 and the queue is not full.
- R13: Characters leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample tick, one-cycle pulse, 16 per bit |
| wr_valid | input | 1 | Push a character into the queue |
| wr_data | input | 8 | Character to push |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cts | input | 1 | Clear-to-send, active high |
| cfg_break | input | 1 | Force the line low |
| cfg_dma_en | input | 1 | Enable the DMA request |
| irq_level | input | 6 | Interrupt fill threshold |
| txd | output | 1 | Serial output line, idle high |
| fifo_full | output | 1 | Queue is full |
| busy | output | 1 | Queue non-empty or frame in flight |
| tx_irq | output | 1 | Fill level at or below threshold |
| tx_dma_req | output | 1 | DMA may write a character |

## Verification
A wrong internal state in the sequencer shows on `txd` within one bit time. A stuck or mis-counted bit counter shifts the sampled bit positions and changes the spacing between consecutive start edges. A wrong parity latch or a wrong data width shows up in the bit sampled at mid-bit. Queue pointer or level errors show as reordered or missing characters on the line, and as `fifo_full`, `tx_irq` or `tx_dma_req` reading wrong right after a push. A sequencer that fails to return to idle leaves `busy` high one bit time after the last stop bit.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
    } frame_cfg_t;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [LW-1:0] level_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign full_o  = (level == LW'(DEPTH));
    assign empty_o = (level == '0);
    assign level_o = level;
    assign rdata_o = mem[rd_ptr];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)) else $error("level overflow"); // R9
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && !pop_i |=> level == $past(level)) else $error("push accepted while full"); // R9
endmodule

// File: rtl/stx_framer.sv
module stx_framer
    import stx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16,
    localparam int TW = $clog2(OSR),
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  frame_cfg_t    cfg_i,
    input  logic          can_start_i,
    input  logic [DW-1:0] load_data_i,
    output logic          pop_o,
    output logic          line_o,
    output logic          active_o
);
    tx_state_e     state, state_nx;
    frame_cfg_t    cfg_q;
    logic [TW-1:0] tcnt;
    logic [DW-1:0] shreg;
    logic [IW-1:0] bidx;
    logic          sidx;
    logic          par_q;
    logic          bit_end, last_data, last_stop, load;

    function automatic logic [DW-1:0] width_mask(input logic [1:0] wl);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i < (DW - 3 + int'(wl)));
        return m;
    endfunction

    assign bit_end   = tick_i && (tcnt == TW'(OSR - 1));
    assign last_data = (bidx == IW'(cfg_q.wlen) + IW'(DW - 4));
    assign last_stop = (sidx == cfg_q.two_stop);

    // next-state logic
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: if (can_start_i) begin
                load     = 1'b1;
                state_nx = ST_START;
            end
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP: if (bit_end && last_stop) begin
                if (can_start_i) begin
                    load     = 1'b1;
                    state_nx = ST_START;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            tcnt  <= '0;
            shreg <= '0;
            bidx  <= '0;
            sidx  <= 1'b0;
            par_q <= 1'b0;
        end else begin
            if (load) begin
                cfg_q <= cfg_i;
                shreg <= load_data_i;
                par_q <= cfg_i.par_even ? ^(load_data_i & width_mask(cfg_i.wlen))
                                        : ~^(load_data_i & width_mask(cfg_i.wlen));
            end else if (state == ST_DATA && bit_end) begin
                shreg <= shreg >> 1;
            end
            if (state == ST_IDLE || bit_end) tcnt <= '0;
            else if (tick_i)                 tcnt <= tcnt + 1'b1;
            if (state == ST_START)              bidx <= '0;
            else if (state == ST_DATA && bit_end) bidx <= bidx + 1'b1;
            if (state != ST_STOP) sidx <= 1'b0;
            else if (bit_end)     sidx <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        pop_o    = load;
        active_o = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   line_o = 1'b1;
            ST_START:  line_o = 1'b0;
            ST_DATA:   line_o = shreg[0];
            ST_PARITY: line_o = par_q;
            ST_STOP:   line_o = 1'b1;
            default:   line_o = 1'b1;
        endcase
    end

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && state != ST_IDLE |=> $stable(tcnt) && state == $past(state)) else $error("advance without tick"); // R5
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import stx_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 32,
    parameter int OSR     = 16,
    parameter int IRQ_MIN = 4,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_two_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic          cfg_cts_en,
    input  logic          cts,
    input  logic          cfg_break,
    input  logic          cfg_dma_en,
    input  logic [LW-1:0] irq_level,
    output logic          txd,
    output logic          fifo_full,
    output logic          busy,
    output logic          tx_irq,
    output logic          tx_dma_req
);
    logic [DW-1:0] head;
    logic          empty, pop, line, active, can_start;
    logic [LW-1:0] level, thr_eff;
    frame_cfg_t    cfg;

    assign cfg       = '{wlen: cfg_wlen, two_stop: cfg_two_stop,
                         par_en: cfg_par_en, par_even: cfg_par_even};
    assign can_start = !empty && (!cfg_cts_en || cts);

    stx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(wr_valid), .wdata_i(wr_data), .pop_i(pop),
        .rdata_o(head), .empty_o(empty), .full_o(fifo_full), .level_o(level)
    );

    stx_framer #(.DW(DW), .OSR(OSR)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .cfg_i(cfg),
        .can_start_i(can_start), .load_data_i(head),
        .pop_o(pop), .line_o(line), .active_o(active)
    );

    assign thr_eff    = (irq_level < LW'(IRQ_MIN)) ? LW'(IRQ_MIN) : irq_level;
    assign txd        = cfg_break ? 1'b0 : line;
    assign busy       = active || !empty;
    assign tx_irq     = (level <= thr_eff);
    assign tx_dma_req = cfg_dma_en && !fifo_full;

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) && $past(cfg_cts_en) |-> $past(cts)) else $error("start without cts"); // R6
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cfg_break |-> txd) else $error("idle line low"); // R10
endmodule

// File: tb/serial_tx_test.sv
module serial_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic       cfg_cts_en = 1'b0, cts = 1'b1, cfg_break = 1'b0, cfg_dma_en = 1'b1;
    logic [5:0] irq_level = 6'd8;
    logic       txd, fifo_full, busy, tx_irq, tx_dma_req;

    int n_checks = 0, n_fail = 0, tick_div = 1, cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_tx uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_valid(wr_valid), .wr_data(wr_data),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_cts_en(cfg_cts_en), .cts(cts), .cfg_break(cfg_break),
        .cfg_dma_en(cfg_dma_en), .irq_level(irq_level), .txd(txd), .fifo_full(fifo_full),
        .busy(busy), .tx_irq(tx_irq), .tx_dma_req(tx_dma_req)
    );

    initial begin : tickgen
        int dc;
        dc = 0;
        forever begin
            @(negedge clk);
            if (dc >= tick_div - 1) begin os_tick = 1'b1; dc = 0; end
            else begin os_tick = 1'b0; dc++; end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Receive one frame per the current config; returns the start cycle.
    task automatic rx_char(input logic [7:0] exp, input string tag, output int t0);
        int nb, bitc, ones, tmo;
        logic [7:0] got;
        logic b;
        nb   = int'(cfg_wlen) + 5;
        bitc = 16 * tick_div;
        got  = '0;
        ones = 0;
        tmo  = 0;
        t0   = 0;
        @(negedge clk);
        while (txd !== 1'b0 && tmo < 20000) begin @(negedge clk); tmo++; end
        t0 = cyc;
        repeat (bitc / 2 - 1) @(negedge clk);
        check(txd == 1'b0, {tag, " start bit"}, txd, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (bitc) @(negedge clk);
            got[i] = txd;
            if (txd) ones++;
        end
        check(got == (exp & ((8'd1 << nb) - 8'd1)), {tag, " data"}, got, exp & ((8'd1 << nb) - 8'd1));
        if (cfg_par_en) begin
            repeat (bitc) @(negedge clk);
            b = txd;
            ones += int'(b);
            check((ones % 2) == (cfg_par_even ? 0 : 1), {tag, " parity R3"}, b, ones);
        end
        for (int s = 0; s <= int'(cfg_two_stop); s++) begin
            repeat (bitc) @(negedge clk);
            check(txd == 1'b1, {tag, " stop R4"}, txd, 1);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(fifo_full == 1'b0, "R1 full", fifo_full, 0);
        check(tx_irq == 1'b1, "R1 irq", tx_irq, 1);
        check(tx_dma_req == 1'b1, "R1 dma", tx_dma_req, 1);
    endtask

    task automatic t_basic;
        int a, b, c;
        cfg_wlen = 2'd3; cfg_par_en = 0; cfg_two_stop = 0;
        push(8'hA5); push(8'h3C); push(8'h81);
        rx_char(8'hA5, "R2 R13 first", a);
        rx_char(8'h3C, "R2 R13 second", b);
        rx_char(8'h81, "R2 R13 third", c);
        check(c - b == 160, "R4 spacing 8N1", c - b, 160);
    endtask

    task automatic t_wlen;
        int a;
        cfg_wlen = 2'd0;
        push(8'hF3);
        rx_char(8'hF3, "R2 five bits", a);
        cfg_wlen = 2'd2;
        push(8'hD6);
        rx_char(8'hD6, "R2 seven bits", a);
        cfg_wlen = 2'd3;
    endtask

    task automatic t_parity;
        int a;
        cfg_par_en = 1; cfg_par_even = 1;
        push(8'h07);
        rx_char(8'h07, "R3 even", a);
        cfg_par_even = 0;
        push(8'h07);
        rx_char(8'h07, "R3 odd", a);
        push(8'h00);
        rx_char(8'h00, "R3 odd zero", a);
        cfg_par_en = 0;
    endtask

    task automatic t_stop2;
        int a, b;
        cfg_two_stop = 1;
        push(8'h55); push(8'hAA);
        rx_char(8'h55, "R4 two stop a", a);
        rx_char(8'hAA, "R4 two stop b", b);
        check(b - a == 176, "R4 spacing 8N2", b - a, 176);
        cfg_two_stop = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_tick;
        int a, b, c;
        tick_div = 3;
        push(8'h12); push(8'h34); push(8'h56);
        rx_char(8'h12, "R5 slow a", a);
        rx_char(8'h34, "R5 slow b", b);
        rx_char(8'h56, "R5 slow c", c);
        check(c - b == 480, "R5 bit 16 ticks", c - b, 480);
        repeat (60) @(negedge clk);
        tick_div = 1;
    endtask

    task automatic t_cts;
        int a;
        bit stayed;
        cfg_cts_en = 1; cts = 0;
        push(8'h9B);
        stayed = 1;
        repeat (100) begin @(negedge clk); if (txd !== 1'b1) stayed = 0; end
        check(stayed, "R6 held by cts", stayed, 1);
        cts = 1;
        rx_char(8'h9B, "R6 released", a);
        push(8'h11); push(8'h22);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        cts = 0;
        repeat (30) @(negedge clk);
        // first frame already started; finish it by sampling remaining bits
        repeat (16 * 9 - 30 + 8) @(negedge clk);
        check(txd == 1'b1, "R7 stop of cut frame", txd, 1);
        stayed = 1;
        repeat (200) begin @(negedge clk); if (txd !== 1'b1) stayed = 0; end
        check(stayed, "R7 next held", stayed, 1);
        check(busy == 1'b1, "R7 busy while pending", busy, 1);
        cts = 1;
        rx_char(8'h22, "R7 resumed", a);
        cfg_cts_en = 0; cts = 0;
        push(8'h6E);
        rx_char(8'h6E, "R6 cts ignored", a);
        cts = 1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_break;
        bit low;
        cfg_break = 1;
        low = 1;
        repeat (60) begin @(negedge clk); if (txd !== 1'b0) low = 0; end
        check(low, "R8 held low", low, 1);
        cfg_break = 0;
        @(negedge clk);
        check(txd == 1'b1, "R8 released", txd, 1);
    endtask

    task automatic t_fifo;
        int a;
        bit quiet;
        cfg_cts_en = 1; cts = 0; irq_level = 6'd0;
        for (int i = 0; i < 4; i++) push(8'(i));
        @(negedge clk);
        check(tx_irq == 1'b1, "R11 level4 thr0", tx_irq, 1);
        push(8'd4);
        @(negedge clk);
        check(tx_irq == 1'b0, "R11 level5 thr0", tx_irq, 0);
        irq_level = 6'd8;
        @(negedge clk);
        check(tx_irq == 1'b1, "R11 level5 thr8", tx_irq, 1);
        for (int i = 5; i < 9; i++) push(8'(i));
        @(negedge clk);
        check(tx_irq == 1'b0, "R11 level9 thr8", tx_irq, 0);
        for (int i = 9; i < 31; i++) push(8'(i));
        @(negedge clk);
        check(fifo_full == 1'b0 && tx_dma_req == 1'b1, "R12 31 entries", {fifo_full, tx_dma_req}, 1);
        push(8'd31);
        @(negedge clk);
        check(fifo_full == 1'b1, "R9 full at 32", fifo_full, 1);
        check(tx_dma_req == 1'b0, "R12 no dma when full", tx_dma_req, 0);
        push(8'hEE);
        cts = 1;
        for (int i = 0; i < 32; i++) rx_char(8'(i), "R9 R13 drain", a);
        quiet = 1;
        repeat (100) begin @(negedge clk); if (txd !== 1'b1) quiet = 0; end
        check(quiet, "R9 dropped push not sent", quiet, 1);
        cfg_cts_en = 0;
        cfg_dma_en = 0;
        @(negedge clk);
        check(tx_dma_req == 1'b0, "R12 dma disabled", tx_dma_req, 0);
        cfg_dma_en = 1;
    endtask

    task automatic t_busy;
        int a;
        push(8'h4D);
        rx_char(8'h4D, "R10 frame", a);
        check(busy == 1'b1, "R10 busy in stop", busy, 1);
        repeat (9) @(negedge clk);
        check(busy == 1'b0, "R10 idle after stop", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wlen();
        t_parity();
        t_stop2();
        t_tick();
        t_cts();
        t_break();
        t_fifo();
        t_busy();
        finish_run();
    end
endmodule